// File: doc/BRIEF.md
# Cartridge Bank and Nametable Mapper

This block is the banking core of a game cartridge. On the CPU side it decodes writes into the upper half of the program space. Those writes load three switchable 8 KB program-ROM window numbers, a save-RAM protect byte and twelve 1 KB video bank numbers. It then turns every CPU address into a program-ROM address and a save-RAM address with a write strobe.

On the video side it turns each video address into a pattern-ROM address. A video bank loaded with a value of 0xE0 or higher, when the substitution is permitted, is served from the console's internal nametable RAM instead of ROM. In that case the block raises a select line and supplies the RAM page bit.

All register updates happen on the rising clock edge of a CPU write. All address translation is combinational from the current address and the register state.

Top module: `cart_nt_mapper`

## Requirements
- R1: A CPU write to 0x8000–0xDFFF loads video bank register i = cpu_addr[14:11] (0–11) with the data byte. A video access with ppu_addr[13:10] = i that is mapped to ROM gives chr_rom_addr = {value masked to CHR_AW-10 bits, ppu_addr[9:0]}.
- R2: If the loaded value is 0xE0 or higher and substitution is permitted, that bank selects internal RAM: ciram_sel = 1 and ciram_a10 = bit 0 of the value. A value below 0xE0 selects ROM (ciram_sel = 0).
- R3: Bit 6 of a byte written to 0xE800–0xEFFF forbids substitution for banks 0–3, and bit 7 forbids it for banks 4–7. Banks 8–11 are always permitted. The permission is taken when the bank register is written, so later changes to bits 6 and 7 do not remap banks already loaded.
- R4: Writes to 0xE000–0xE7FF, 0xE800–0xEFFF and 0xF000–0xF7FF load data bits 5:0 as the bank number of the windows at 0x8000, 0xA000 and 0xC000. For addresses in 0x8000–0xFFFF, prg_rom_addr = {bank masked to PRG_AW-13 bits, cpu_addr[12:0]}.
- R5: The window at 0xE000–0xFFFF always uses the last bank: the bank field of prg_rom_addr is all ones.
- R6: A write to 0xF800–0xFFFF loads the protect byte. For each page i (0–3), prg_ram_wpage_en[i] = bit 6 & ~bit i. prg_ram_addr = cpu_addr[12:0]. prg_ram_we is 1 only when cpu_we is high, cpu_addr is in 0x6000–0x7FFF, and the page cpu_addr[12:11] is enabled.
- R7: After reset the protect byte is 0, so all pages are write-locked. Program banks are 0, video banks 0–7 are ROM bank 0, and video banks 8–11 select internal RAM pages 0, 0, 1, 1.
- R8: ciram_we equals ppu_we only while the addressed video bank selects internal RAM. Video writes to ROM-mapped banks give no strobe.
- R9: Video addresses 0x3000–0x3FFF (ppu_addr[13:10] = 12–15) use video bank registers 8–11.
- R10: A cycle with cpu_we low, or a write below 0x8000, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| ppu_addr | input | 14 | Video address |
| ppu_we | input | 1 | Video write strobe |
| prg_rom_addr | output | PRG_AW | Translated program-ROM address |
| prg_ram_addr | output | 13 | Save-RAM address |
| prg_ram_we | output | 1 | Save-RAM write strobe |
| prg_ram_wpage_en | output | 4 | Per-page save-RAM write enable |
| chr_rom_addr | output | CHR_AW | Translated pattern-ROM address |
| ciram_sel | output | 1 | Video access served by internal nametable RAM |
| ciram_a10 | output | 1 | Internal RAM page bit |
| ciram_we | output | 1 | Internal RAM write strobe |

## Verification
The assertions assume that rst_n is held low from time zero until at least one clock edge has passed. They also assume that cpu_we and cpu_addr change only away from the rising edge, so each write is seen at exactly one edge. The bench drives every input on the falling edge, keeps cpu_we low throughout reset, and holds each write for one full cycle. This keeps the protect-byte stability property and the address checks well defined.

// File: rtl/cnm_pkg.sv
package cnm_pkg;
   localparam int NUM_VBANKS   = 12;
   localparam int NT_FIRST     = 8;
   localparam int PRG_FIELD_W  = 6;
   localparam int VB_W         = 8;
   localparam int NUM_RAM_PAGE = 4;
   localparam logic [VB_W-1:0] NT_THRESH = 8'hE0;

   typedef struct packed {
      logic       vbank;
      logic [3:0] vidx;
      logic       win0;
      logic       win1;
      logic       win2;
      logic       prot;
   } cpu_wr_t;

   function automatic cpu_wr_t decode_write(input logic we, input logic [15:0] a);
      cpu_wr_t d;
      d.vbank = we && a[15] && (a[14:13] != 2'b11);
      d.vidx  = a[14:11];
      d.win0  = we && (a[15:11] == 5'b11100);
      d.win1  = we && (a[15:11] == 5'b11101);
      d.win2  = we && (a[15:11] == 5'b11110);
      d.prot  = we && (a[15:11] == 5'b11111);
      return d;
   endfunction
endpackage

// File: rtl/cnm_prg_regs.sv
module cnm_prg_regs
   import cnm_pkg::*;
#(
   parameter int PRG_AW = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_win0,
   input  logic              wr_win1,
   input  logic              wr_win2,
   input  logic              wr_prot,
   input  logic [7:0]        wdata,
   input  logic [1:0]        win,
   input  logic [12:0]       offset,
   output logic [PRG_AW-1:0] prg_rom_addr,
   output logic              nt_dis_lo,
   output logic              nt_dis_hi,
   output logic [NUM_RAM_PAGE-1:0] wpage_en
);
   localparam int PRG_BW = PRG_AW - 13;

   logic [PRG_FIELD_W-1:0] win_bank [3];
   logic [2:0]             win_wr;
   logic [7:0]             prot_q;
   logic [PRG_BW-1:0]      bank_sel;

   assign win_wr = {wr_win2, wr_win1, wr_win0};

   for (genvar w = 0; w < 3; w++) begin : g_win
      always_ff @(posedge clk) begin
         if (!rst_n)         win_bank[w] <= '0;
         else if (win_wr[w]) win_bank[w] <= wdata[PRG_FIELD_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nt_dis_lo <= 1'b0;
         nt_dis_hi <= 1'b0;
      end else if (wr_win1) begin
         nt_dis_lo <= wdata[6];
         nt_dis_hi <= wdata[7];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       prot_q <= '0;
      else if (wr_prot) prot_q <= wdata;
   end

   for (genvar p = 0; p < NUM_RAM_PAGE; p++) begin : g_page
      assign wpage_en[p] = prot_q[6] & ~prot_q[p];
   end

   always_comb begin
      if (win == 2'b11) bank_sel = '1;
      else              bank_sel = win_bank[win][PRG_BW-1:0];
   end

   assign prg_rom_addr = {bank_sel, offset};

   logic unused_prot;
   assign unused_prot = ^{prot_q[7], prot_q[5:4]};
endmodule

// File: rtl/cnm_vbank_regs.sv
module cnm_vbank_regs
   import cnm_pkg::*;
#(
   parameter int CHR_AW = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_vbank,
   input  logic [3:0]        wr_idx,
   input  logic [7:0]        wdata,
   input  logic              nt_dis_lo,
   input  logic              nt_dis_hi,
   input  logic [13:0]       ppu_addr,
   output logic [CHR_AW-1:0] chr_rom_addr,
   output logic              ciram_sel,
   output logic              ciram_a10
);
   localparam int CHR_BW = CHR_AW - 10;

   logic [VB_W-1:0]       bank_val [NUM_VBANKS];
   logic [NUM_VBANKS-1:0] bank_nt;
   logic                  want_nt;
   logic [3:0]            rd_idx;

   assign want_nt = (wdata >= NT_THRESH);

   for (genvar g = 0; g < NUM_VBANKS; g++) begin : g_bank
      logic permit;
      if (g < 4) begin : g_lo
         assign permit = ~nt_dis_lo;
      end else if (g < NT_FIRST) begin : g_hi
         assign permit = ~nt_dis_hi;
      end else begin : g_nt
         assign permit = 1'b1;
      end

      localparam logic [VB_W-1:0] RST_VAL =
         (g >= NT_FIRST) ? VB_W'((g - NT_FIRST) >> 1) : '0;
      localparam logic RST_NT = (g >= NT_FIRST);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bank_val[g] <= RST_VAL;
            bank_nt[g]  <= RST_NT;
         end else if (wr_vbank && (wr_idx == 4'(g))) begin
            bank_val[g] <= wdata;
            bank_nt[g]  <= want_nt & permit;
         end
      end
   end

   always_comb begin
      if (ppu_addr[13:12] == 2'b11) rd_idx = {2'b10, ppu_addr[11:10]};
      else                          rd_idx = ppu_addr[13:10];
   end

   assign ciram_sel    = bank_nt[rd_idx];
   assign ciram_a10    = bank_val[rd_idx][0];
   assign chr_rom_addr = {bank_val[rd_idx][CHR_BW-1:0], ppu_addr[9:0]};
endmodule

// File: rtl/cart_nt_mapper.sv
module cart_nt_mapper
   import cnm_pkg::*;
#(
   parameter int PRG_AW = 19,
   parameter int CHR_AW = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_wdata,
   input  logic              cpu_we,
   input  logic [13:0]       ppu_addr,
   input  logic              ppu_we,
   output logic [PRG_AW-1:0] prg_rom_addr,
   output logic [12:0]       prg_ram_addr,
   output logic              prg_ram_we,
   output logic [3:0]        prg_ram_wpage_en,
   output logic [CHR_AW-1:0] chr_rom_addr,
   output logic              ciram_sel,
   output logic              ciram_a10,
   output logic              ciram_we
);
   localparam int PRG_BW = PRG_AW - 13;
   localparam int CHR_BW = CHR_AW - 10;

   if (PRG_BW < 1 || PRG_BW > PRG_FIELD_W) begin : g_bad_prg
      $error("PRG_AW must lie in 14..19");
   end
   if (CHR_BW < 1 || CHR_BW > VB_W) begin : g_bad_chr
      $error("CHR_AW must lie in 11..18");
   end

   cpu_wr_t wr;
   logic    nt_dis_lo, nt_dis_hi;
   logic    in_ram_win;

   assign wr = decode_write(cpu_we, cpu_addr);

   cnm_prg_regs #(.PRG_AW(PRG_AW)) u_prg (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_win0      (wr.win0),
      .wr_win1      (wr.win1),
      .wr_win2      (wr.win2),
      .wr_prot      (wr.prot),
      .wdata        (cpu_wdata),
      .win          (cpu_addr[14:13]),
      .offset       (cpu_addr[12:0]),
      .prg_rom_addr (prg_rom_addr),
      .nt_dis_lo    (nt_dis_lo),
      .nt_dis_hi    (nt_dis_hi),
      .wpage_en     (prg_ram_wpage_en)
   );

   cnm_vbank_regs #(.CHR_AW(CHR_AW)) u_vbank (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_vbank     (wr.vbank),
      .wr_idx       (wr.vidx),
      .wdata        (cpu_wdata),
      .nt_dis_lo    (nt_dis_lo),
      .nt_dis_hi    (nt_dis_hi),
      .ppu_addr     (ppu_addr),
      .chr_rom_addr (chr_rom_addr),
      .ciram_sel    (ciram_sel),
      .ciram_a10    (ciram_a10)
   );

   assign in_ram_win   = (cpu_addr[15:13] == 3'b011);
   assign prg_ram_addr = cpu_addr[12:0];
   assign prg_ram_we   = cpu_we && in_ram_win && prg_ram_wpage_en[cpu_addr[12:11]];
   assign ciram_we     = ppu_we && ciram_sel;
endmodule

// File: rtl/cnm_chk.sv
module cnm_chk #(
   parameter int PRG_AW = 19,
   parameter int CHR_AW = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic [15:0]       cpu_addr,
   input logic              cpu_we,
   input logic [13:0]       ppu_addr,
   input logic              ppu_we,
   input logic [PRG_AW-1:0] prg_rom_addr,
   input logic              prg_ram_we,
   input logic [3:0]        prg_ram_wpage_en,
   input logic [CHR_AW-1:0] chr_rom_addr,
   input logic              ciram_sel,
   input logic              ciram_we
);
   AST_RAM_WE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      prg_ram_we |-> (cpu_we && cpu_addr[15:13] == 3'b011)); // R6
   AST_RAM_WE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      prg_ram_we |-> prg_ram_wpage_en[cpu_addr[12:11]]); // R6
   AST_LAST_WINDOW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr[15:13] == 3'b111) |-> (prg_rom_addr[PRG_AW-1:13] == '1)); // R5
   AST_PRG_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_addr[15] |-> (prg_rom_addr[12:0] == cpu_addr[12:0])); // R4
   AST_CHR_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !ciram_sel |-> (chr_rom_addr[9:0] == ppu_addr[9:0])); // R1
   AST_CIRAM_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      ciram_we |-> (ppu_we && ciram_sel)); // R8
   AST_PROT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_we && cpu_addr[15:11] == 5'h1F) |=> $stable(prg_ram_wpage_en)); // R10
endmodule

bind cart_nt_mapper cnm_chk #(.PRG_AW(PRG_AW), .CHR_AW(CHR_AW)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cpu_addr         (cpu_addr),
   .cpu_we           (cpu_we),
   .ppu_addr         (ppu_addr),
   .ppu_we           (ppu_we),
   .prg_rom_addr     (prg_rom_addr),
   .prg_ram_we       (prg_ram_we),
   .prg_ram_wpage_en (prg_ram_wpage_en),
   .chr_rom_addr     (chr_rom_addr),
   .ciram_sel        (ciram_sel),
   .ciram_we         (ciram_we)
);

// File: tb/cart_nt_mapper_tb.sv
`timescale 1ns/1ps
module cart_nt_mapper_tb;
   localparam int PRG_AW = 19;
   localparam int CHR_AW = 18;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [15:0]       cpu_addr = '0;
   logic [7:0]        cpu_wdata = '0;
   logic              cpu_we = 1'b0;
   logic [13:0]       ppu_addr = '0;
   logic              ppu_we = 1'b0;
   logic [PRG_AW-1:0] prg_rom_addr;
   logic [12:0]       prg_ram_addr;
   logic              prg_ram_we;
   logic [3:0]        prg_ram_wpage_en;
   logic [CHR_AW-1:0] chr_rom_addr;
   logic              ciram_sel, ciram_a10, ciram_we;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cart_nt_mapper #(.PRG_AW(PRG_AW), .CHR_AW(CHR_AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_we(cpu_we), .ppu_addr(ppu_addr), .ppu_we(ppu_we),
      .prg_rom_addr(prg_rom_addr), .prg_ram_addr(prg_ram_addr),
      .prg_ram_we(prg_ram_we), .prg_ram_wpage_en(prg_ram_wpage_en),
      .chr_rom_addr(chr_rom_addr), .ciram_sel(ciram_sel),
      .ciram_a10(ciram_a10), .ciram_we(ciram_we)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
      @(negedge clk);
      cpu_we = 1'b0; cpu_addr = 16'h0000;
   endtask

   task automatic vid_look(input logic [13:0] a);
      ppu_addr = a;
      #1;
   endtask

   task automatic prg_look(input logic [15:0] a);
      cpu_addr = a;
      #1;
   endtask

   task automatic t_reset;
      prg_look(16'h8123);
      chk("R7 prg bank0 at reset", 32'(prg_rom_addr), 32'h00123);
      chk("R7 wpage locked", 32'(prg_ram_wpage_en), 32'h0);
      vid_look(14'h0155);
      chk("R7 vbank0 rom", 32'({ciram_sel, chr_rom_addr}), 32'h00155);
      for (int i = 0; i < 4; i++) begin
         vid_look(14'(14'h2000 + i * 14'h0400));
         chk("R7 nt bank sel", 32'(ciram_sel), 32'h1);
         chk("R7 nt page", 32'(ciram_a10), 32'(i >> 1));
      end
   endtask

   task automatic t_chr_rom;
      cpu_wr(16'h8800, 8'h37);
      cpu_wr(16'hB000, 8'hDF);
      vid_look(14'h0555);
      chk("R1 bank1 rom addr", 32'(chr_rom_addr), 32'({8'h37, 10'h155}));
      chk("R2 below threshold rom", 32'(ciram_sel), 32'h0);
      vid_look(14'h1AAA);
      chk("R1 bank6 rom addr", 32'(chr_rom_addr), 32'({8'hDF, 10'h2AA}));
   endtask

   task automatic t_nt_sub;
      cpu_wr(16'h9000, 8'hE1);
      cpu_wr(16'h9800, 8'hE0);
      vid_look(14'h0800);
      chk("R2 bank2 nt sel", 32'({ciram_sel, ciram_a10}), 32'h3);
      vid_look(14'h0C00);
      chk("R2 bank3 nt sel", 32'({ciram_sel, ciram_a10}), 32'h2);
   endtask

   task automatic t_gating;
      cpu_wr(16'hE800, 8'h40);
      cpu_wr(16'h8000, 8'hE1);
      cpu_wr(16'hA000, 8'hE1);
      vid_look(14'h0000);
      chk("R3 low half disabled", 32'(ciram_sel), 32'h0);
      chk("R3 low half rom addr", 32'(chr_rom_addr), 32'({8'hE1, 10'h000}));
      vid_look(14'h1000);
      chk("R3 high half allowed", 32'({ciram_sel, ciram_a10}), 32'h3);
      cpu_wr(16'hE800, 8'h80);
      cpu_wr(16'hA800, 8'hE0);
      cpu_wr(16'hC000, 8'hE0);
      vid_look(14'h1400);
      chk("R3 high half disabled", 32'(ciram_sel), 32'h0);
      vid_look(14'h2000);
      chk("R3 bank8 always", 32'({ciram_sel, ciram_a10}), 32'h2);
      cpu_wr(16'hE800, 8'h00);
      vid_look(14'h0000);
      chk("R3 taken at write time", 32'(ciram_sel), 32'h0);
      cpu_wr(16'h8000, 8'hE1);
      vid_look(14'h0000);
      chk("R3 rewrite now allowed", 32'(ciram_sel), 32'h1);
   endtask

   task automatic t_prg;
      cpu_wr(16'hE000, 8'hC5);
      cpu_wr(16'hE800, 8'h3A);
      cpu_wr(16'hF7FF, 8'h7F);
      prg_look(16'h8ABC);
      chk("R4 window0", 32'(prg_rom_addr), 32'({6'h05, 13'h0ABC}));
      prg_look(16'hB001);
      chk("R4 window1", 32'(prg_rom_addr), 32'({6'h3A, 13'h1001}));
      prg_look(16'hC010);
      chk("R4 window2", 32'(prg_rom_addr), 32'({6'h3F, 13'h0010}));
      cpu_wr(16'hE000, 8'h00);
      prg_look(16'hF234);
      chk("R5 last window", 32'(prg_rom_addr), 32'({6'h3F, 13'h1234}));
      prg_look(16'hE000);
      chk("R5 last window base", 32'(prg_rom_addr), 32'({6'h3F, 13'h0000}));
   endtask

   task automatic t_protect;
      cpu_wr(16'hF800, 8'h45);
      chk("R6 page enables", 32'(prg_ram_wpage_en), 32'hA);
      @(negedge clk);
      cpu_addr = 16'h6800; cpu_wdata = 8'h11; cpu_we = 1'b1; #1;
      chk("R6 page1 write", 32'({prg_ram_we, prg_ram_addr}), 32'({1'b1, 13'h0800}));
      cpu_addr = 16'h7000; #1;
      chk("R6 page2 blocked", 32'(prg_ram_we), 32'h0);
      cpu_addr = 16'h7FFF; #1;
      chk("R6 page3 write", 32'({prg_ram_we, prg_ram_addr}), 32'({1'b1, 13'h1FFF}));
      cpu_addr = 16'h5FFF; #1;
      chk("R6 outside ram window", 32'(prg_ram_we), 32'h0);
      @(negedge clk);
      cpu_we = 1'b0; cpu_addr = 16'h0000;
      cpu_wr(16'hFFFF, 8'h0F);
      chk("R6 bit6 clear locks all", 32'(prg_ram_wpage_en), 32'h0);
   endtask

   task automatic t_ciram_we;
      vid_look(14'h2400);
      ppu_we = 1'b1; #1;
      chk("R8 nt write strobe", 32'(ciram_we), 32'h1);
      vid_look(14'h0400);
      chk("R8 rom write ignored", 32'(ciram_we), 32'h0);
      ppu_we = 1'b0; #1;
      vid_look(14'h2400);
      chk("R8 no strobe without write", 32'(ciram_we), 32'h0);
   endtask

   task automatic t_mirror;
      cpu_wr(16'hD800, 8'hE1);
      cpu_wr(16'hD000, 8'h12);
      vid_look(14'h3C00);
      chk("R9 0x3C00 uses bank11", 32'({ciram_sel, ciram_a10}), 32'h3);
      vid_look(14'h3800);
      chk("R9 0x3800 uses bank10", 32'({ciram_sel, chr_rom_addr}), 32'({1'b0, 8'h12, 10'h000}));
   endtask

   task automatic t_ignored;
      @(negedge clk);
      cpu_addr = 16'hF800; cpu_wdata = 8'h40; cpu_we = 1'b0;
      @(negedge clk);
      cpu_addr = 16'hE000; cpu_wdata = 8'h2A;
      @(negedge clk);
      chk("R10 no write strobe protect", 32'(prg_ram_wpage_en), 32'h0);
      cpu_wr(16'h5000, 8'hFF);
      cpu_wr(16'h4800, 8'hE0);
      prg_look(16'h8000);
      chk("R10 bank0 unchanged", 32'(prg_rom_addr), 32'h0);
      chk("R10 protect unchanged", 32'(prg_ram_wpage_en), 32'h0);
      vid_look(14'h0400);
      chk("R10 vbank1 unchanged", 32'({ciram_sel, chr_rom_addr}), 32'({1'b0, 8'h37, 10'h000}));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_chr_rom();
      t_nt_sub();
      t_gating();
      t_prg();
      t_protect();
      t_ciram_we();
      t_mirror();
      t_ignored();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule